// File: doc/BRIEF.md
# UART Mode Register Pointer Bank

This block holds the three mode registers of one serial channel behind a single bus address. The address has no register index. An internal pointer picks which of the three registers a bus access reaches. Each read or write moves the pointer one step forward, and the pointer stops at the third register. A small set of pointer commands, given as a strobe with a 4-bit code, moves the pointer back so that software can start a new configuration pass.

The first register stores only its upper four bits. Its lower four bits always read as ones. Its top bit drives the enable of the receive FIFO watchdog timer. Its bit 6, together with bit 6 of the second register, forms a two-bit receiver interrupt threshold select. All other stored bits are brought out in parallel for the channel logic to decode.

Top module: `uart_mode_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every implemented mode bit to 0 and sets the pointer to 1, so the first access after reset reaches the second register.
- R2: An access is `sel` high together with `rd_stb` or `wr_stb`, or both. Both strobes in one cycle count as one access. An access at a clock edge moves the pointer from 0 to 1, or from 1 to 2.
- R3: When the pointer is 2, accesses leave it at 2 until a pointer command or a reset.
- R4: With `cmd_stb` high, code 4'hB sets the pointer to 0 and code 4'h1 sets it to 1. Any other code has no effect on the pointer.
- R5: When a recognised pointer command and an access fall in the same cycle, the command decides the pointer and there is no increment. A write in that cycle still lands in the register the pointer selected before the edge.
- R6: A write stores `wdata` into the register the pointer selects. The second and third registers store all 8 bits.
- R7: The first register stores only `wdata[7:4]`. While the pointer is 0, `rdata[3:0]` reads 4'hF whatever was written.
- R8: While `sel` is high, `rdata` shows the register the pointer selects, without a clock delay. While `sel` is low, `rdata` is 0.
- R9: `wdog_en` equals bit 7 of the first register. `rx_thr_sel[1]` equals bit 6 of the first register, and `rx_thr_sel[0]` equals bit 6 of the second register.
- R10: Strobes with `sel` low change neither the pointer nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select for the shared mode address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| cmd_stb | input | 1 | Pointer command strobe |
| cmd_code | input | 4 | Pointer command code |
| rdata | output | 8 | Read data of the selected register |
| wdog_en | output | 1 | Receive FIFO watchdog timer enable |
| rx_thr_sel | output | 2 | Receiver interrupt threshold select pair |
| mr0_hi | output | 4 | Stored upper bits of the first register |
| mr1_q | output | 8 | Second register contents |
| mr2_q | output | 8 | Third register contents |

## Verification
A pointer command and a bus access can fall in the same cycle. In that case the command must override the increment, while the write still goes to the old pointer target. Directed steps pair code 4'hB with a write at the saturated pointer. They also pair an unrecognised code with a read, to show that such a code leaves the increment in place. The random phase then draws command strobes and accesses independently, so many cycles carry both. After every edge, a bench model decides the pointer from the stated priority. The pointer is not a port, so it is judged through the register that `rdata` shows, along with the parallel register outputs.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
   localparam int         MODE_DATA_W   = 8;
   localparam int         MODE_CMD_W    = 4;
   localparam logic [3:0] MODE_CMD_TO_0 = 4'hB;
   localparam logic [3:0] MODE_CMD_TO_1 = 4'h1;
endpackage

// File: rtl/uart_mode_ptr.sv
module uart_mode_ptr #(
   parameter int NUM_MR  = 3,
   parameter int CMD_W   = 4,
   parameter logic [CMD_W-1:0] CODE_TO_0 = uart_mode_pkg::MODE_CMD_TO_0,
   parameter logic [CMD_W-1:0] CODE_TO_1 = uart_mode_pkg::MODE_CMD_TO_1,
   parameter int RST_IDX = 1,
   localparam int PTR_W  = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             access,
   input  logic             cmd_stb,
   input  logic [CMD_W-1:0] cmd_code,
   output logic [PTR_W-1:0] ptr_q
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_MR - 1);

   logic hit_to_0;
   logic hit_to_1;

   assign hit_to_0 = cmd_stb && (cmd_code == CODE_TO_0);
   assign hit_to_1 = cmd_stb && (cmd_code == CODE_TO_1);

   // commands take priority over the access increment
   always_ff @(posedge clk) begin
      if (rst)
         ptr_q <= PTR_W'(RST_IDX);
      else if (hit_to_0)
         ptr_q <= '0;
      else if (hit_to_1)
         ptr_q <= PTR_W'(1);
      else if (access && (ptr_q != LAST))
         ptr_q <= ptr_q + PTR_W'(1);
   end
endmodule

// File: rtl/uart_mode_regfile.sv
module uart_mode_regfile #(
   parameter int DATA_W  = 8,
   parameter int NUM_MR  = 3,
   parameter int MR0_LSB = 4,
   localparam int PTR_W  = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [PTR_W-1:0]         ptr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [NUM_MR*DATA_W-1:0] view
);
   for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
      if (i == 0 && MR0_LSB > 0) begin : g_part
         // partial register: low bits absent, read back as ones
         logic [DATA_W-1:MR0_LSB] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wr_en && (ptr == PTR_W'(i)))
               q <= wdata[DATA_W-1:MR0_LSB];
         end
         assign view[i*DATA_W +: DATA_W] = {q, {MR0_LSB{1'b1}}};
      end else begin : g_full
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wr_en && (ptr == PTR_W'(i)))
               q <= wdata;
         end
         assign view[i*DATA_W +: DATA_W] = q;
      end
   end
endmodule

// File: rtl/uart_mode_rdmux.sv
module uart_mode_rdmux #(
   parameter int DATA_W = 8,
   parameter int NUM_MR = 3,
   localparam int PTR_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
   input  logic                     sel,
   input  logic [PTR_W-1:0]         ptr,
   input  logic [NUM_MR*DATA_W-1:0] view,
   output logic [DATA_W-1:0]        rdata
);
   always_comb begin
      rdata = '0;
      if (sel) begin
         for (int i = 0; i < NUM_MR; i++) begin
            if (ptr == PTR_W'(i))
               rdata = view[i*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/uart_mode_bank.sv
module uart_mode_bank #(
   parameter int DATA_W   = uart_mode_pkg::MODE_DATA_W,
   parameter int NUM_MR   = 3,
   parameter int CMD_W    = uart_mode_pkg::MODE_CMD_W,
   parameter logic [CMD_W-1:0] CODE_TO_0 = uart_mode_pkg::MODE_CMD_TO_0,
   parameter logic [CMD_W-1:0] CODE_TO_1 = uart_mode_pkg::MODE_CMD_TO_1,
   parameter int MR0_LSB  = 4,
   parameter int RST_IDX  = 1,
   parameter int WDOG_BIT = 7,
   parameter int THR_BIT  = 6,
   localparam int PTR_W   = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sel,
   input  logic                    rd_stb,
   input  logic                    wr_stb,
   input  logic [DATA_W-1:0]       wdata,
   input  logic                    cmd_stb,
   input  logic [CMD_W-1:0]        cmd_code,
   output logic [DATA_W-1:0]       rdata,
   output logic                    wdog_en,
   output logic [1:0]              rx_thr_sel,
   output logic [DATA_W-MR0_LSB-1:0] mr0_hi,
   output logic [DATA_W-1:0]       mr1_q,
   output logic [DATA_W-1:0]       mr2_q
);
   if (NUM_MR != 3) begin : g_bad_num
      $error("uart_mode_bank: NUM_MR must be 3");
   end
   if (MR0_LSB < 1 || MR0_LSB > THR_BIT) begin : g_bad_lsb
      $error("uart_mode_bank: MR0_LSB must lie below the threshold bit");
   end
   if (WDOG_BIT >= DATA_W || THR_BIT >= WDOG_BIT) begin : g_bad_bits
      $error("uart_mode_bank: field bit positions out of range");
   end
   if (CODE_TO_0 == CODE_TO_1) begin : g_bad_codes
      $error("uart_mode_bank: pointer command codes must differ");
   end
   if (RST_IDX >= NUM_MR) begin : g_bad_rst
      $error("uart_mode_bank: reset pointer out of range");
   end

   logic                     access;
   logic                     wr_en;
   logic [PTR_W-1:0]         ptr_q;
   logic [NUM_MR*DATA_W-1:0] view;

   assign access = sel && (rd_stb || wr_stb);
   assign wr_en  = sel && wr_stb;

   uart_mode_ptr #(
      .NUM_MR (NUM_MR),  .CMD_W (CMD_W),
      .CODE_TO_0 (CODE_TO_0), .CODE_TO_1 (CODE_TO_1),
      .RST_IDX (RST_IDX)
   ) u_ptr (
      .clk (clk), .rst (rst), .access (access),
      .cmd_stb (cmd_stb), .cmd_code (cmd_code), .ptr_q (ptr_q)
   );

   uart_mode_regfile #(
      .DATA_W (DATA_W), .NUM_MR (NUM_MR), .MR0_LSB (MR0_LSB)
   ) u_regs (
      .clk (clk), .rst (rst), .wr_en (wr_en),
      .ptr (ptr_q), .wdata (wdata), .view (view)
   );

   uart_mode_rdmux #(
      .DATA_W (DATA_W), .NUM_MR (NUM_MR)
   ) u_rdmux (
      .sel (sel), .ptr (ptr_q), .view (view), .rdata (rdata)
   );

   assign mr0_hi     = view[DATA_W-1:MR0_LSB];
   assign mr1_q      = view[2*DATA_W-1:DATA_W];
   assign mr2_q      = view[3*DATA_W-1:2*DATA_W];
   assign wdog_en    = view[WDOG_BIT];
   assign rx_thr_sel = {view[THR_BIT], view[DATA_W+THR_BIT]};
endmodule

// File: rtl/uart_mode_bank_chk.sv
module uart_mode_bank_chk (
   input logic       clk,
   input logic       rst,
   input logic       sel,
   input logic       rd_stb,
   input logic       wr_stb,
   input logic [7:0] wdata,
   input logic       cmd_stb,
   input logic [3:0] cmd_code,
   input logic [1:0] ptr,
   input logic [7:0] rdata,
   input logic       wdog_en
);
   logic hit0, hit1, acc;
   assign hit0 = cmd_stb && (cmd_code == 4'hB);
   assign hit1 = cmd_stb && (cmd_code == 4'h1);
   assign acc  = sel && (rd_stb || wr_stb);

   a_r1_reset_ptr: assert property (@(posedge clk)
      $fell(rst) |-> (ptr == 2'd1) && !wdog_en);

   a_r2_advance: assert property (@(posedge clk) disable iff (rst)
      (!hit0 && !hit1 && acc && ptr < 2'd2) |=> ptr == $past(ptr) + 2'd1);

   a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
      (!hit0 && !hit1 && ptr == 2'd2) |=> ptr == 2'd2);

   a_r4_cmd_to0: assert property (@(posedge clk) disable iff (rst)
      hit0 |=> ptr == 2'd0);

   a_r5_cmd_beats_access: assert property (@(posedge clk) disable iff (rst)
      (hit1 && acc) |=> ptr == 2'd1);

   a_r7_low_ones: assert property (@(posedge clk) disable iff (rst)
      (sel && ptr == 2'd0) |-> rdata[3:0] == 4'hF);

   a_r8_desel_zero: assert property (@(posedge clk) disable iff (rst)
      !sel |-> rdata == 8'h00);

   a_r9_wdog: assert property (@(posedge clk) disable iff (rst)
      (sel && wr_stb && ptr == 2'd0) |=> wdog_en == $past(wdata[7]));

   a_r10_idle: assert property (@(posedge clk) disable iff (rst)
      (!sel && !hit0 && !hit1) |=> $stable(ptr));
endmodule

bind uart_mode_bank uart_mode_bank_chk u_chk (
   .clk (clk), .rst (rst), .sel (sel), .rd_stb (rd_stb), .wr_stb (wr_stb),
   .wdata (wdata), .cmd_stb (cmd_stb), .cmd_code (cmd_code),
   .ptr (ptr_q), .rdata (rdata), .wdog_en (wdog_en)
);

// File: tb/uart_mode_bank_bench.sv
module uart_mode_bank_bench;
   localparam int P = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, cmd_stb = 1'b0;
   logic [7:0] wdata = '0;
   logic [3:0] cmd_code = '0;
   logic [7:0] rdata, mr1_q, mr2_q;
   logic [3:0] mr0_hi;
   logic       wdog_en;
   logic [1:0] rx_thr_sel;

   int checks = 0;
   int fails  = 0;

   // bench model
   int         m_ptr = 1;
   logic [3:0] m0 = '0;
   logic [7:0] m1 = '0, m2 = '0;

   always #(P/2) clk = ~clk;

   uart_mode_bank u_uart_mode_bank (
      .clk (clk), .rst (rst), .sel (sel), .rd_stb (rd_stb), .wr_stb (wr_stb),
      .wdata (wdata), .cmd_stb (cmd_stb), .cmd_code (cmd_code),
      .rdata (rdata), .wdog_en (wdog_en), .rx_thr_sel (rx_thr_sel),
      .mr0_hi (mr0_hi), .mr1_q (mr1_q), .mr2_q (mr2_q)
   );

   function automatic logic [7:0] exp_rd(input logic s);
      if (!s) return 8'h00;
      case (m_ptr)
         0:       return {m0, 4'hF};
         1:       return m1;
         default: return m2;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_outputs(input string tag);
      chk(tag, rdata, exp_rd(sel));
      chk("R6", {4'h0, mr0_hi}, {4'h0, m0});
      chk("R6", mr1_q, m1);
      chk("R6", mr2_q, m2);
      chk("R9", {7'h0, wdog_en}, {7'h0, m0[3]});
      chk("R9", {6'h0, rx_thr_sel}, {6'h0, m0[2], m1[6]});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sel = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0; cmd_stb = 1'b0;
      @(posedge clk);
      m_ptr = 1; m0 = '0; m1 = '0; m2 = '0;
      #1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk_outputs("R1");
   endtask

   task automatic step(input logic s, input logic r, input logic w, input logic [7:0] d,
                       input logic c, input logic [3:0] cc, input string tag);
      @(negedge clk);
      sel = s; rd_stb = r; wr_stb = w; wdata = d; cmd_stb = c; cmd_code = cc;
      #(P/4);
      chk("R8", rdata, exp_rd(s));
      @(posedge clk);
      if (s && w) begin
         case (m_ptr)
            0:       m0 = d[7:4];
            1:       m1 = d;
            default: m2 = d;
         endcase
      end
      if (c && cc == 4'hB)      m_ptr = 0;
      else if (c && cc == 4'h1) m_ptr = 1;
      else if (s && (r || w) && m_ptr < 2) m_ptr = m_ptr + 1;
      #1;
      chk_outputs(tag);
   endtask

   initial begin
      #(P*150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(posedge clk);
      do_reset();
      step(1, 0, 1, 8'h3C, 0, 4'h0, "R1");  // first write after reset hits second register
      step(1, 0, 1, 8'h5A, 0, 4'h0, "R6");
      step(1, 1, 0, 8'h00, 0, 4'h0, "R3");
      step(1, 1, 0, 8'h00, 0, 4'h0, "R3");
      step(1, 0, 0, 8'h00, 1, 4'hB, "R4");  // pointer to 0
      step(1, 0, 1, 8'hFF, 0, 4'h0, "R7");
      step(1, 0, 0, 8'h00, 1, 4'hB, "R4");
      step(1, 0, 0, 8'h00, 0, 4'h0, "R7");  // low nibble reads ones
      step(1, 0, 1, 8'h90, 0, 4'h0, "R9");
      step(1, 0, 1, 8'h40, 0, 4'h0, "R9");
      step(1, 0, 0, 8'h00, 1, 4'h1, "R4");  // pointer to 1
      step(1, 1, 0, 8'h00, 1, 4'h7, "R4");  // unknown code: access still advances
      step(1, 0, 1, 8'h77, 1, 4'hB, "R5");  // write to old target, pointer to 0
      step(1, 1, 0, 8'h00, 0, 4'h0, "R5");
      step(1, 0, 1, 8'hC3, 1, 4'h1, "R5");
      step(0, 1, 1, 8'hEE, 0, 4'h0, "R10");
      step(1, 0, 0, 8'h00, 0, 4'h0, "R10");
      step(1, 1, 1, 8'h12, 0, 4'h0, "R2");  // both strobes: one step
      step(0, 0, 0, 8'h00, 0, 4'h0, "R8");
      do_reset();
      for (int i = 0; i < 600; i++) begin
         logic s, r, w, c;
         logic [3:0] cc;
         s = ($urandom % 4) != 0;
         r = $urandom % 2;
         w = $urandom % 2;
         c = ($urandom % 5) == 0;
         case ($urandom % 3)
            0:       cc = 4'hB;
            1:       cc = 4'h1;
            default: cc = 4'($urandom);
         endcase
         step(s, r, w, 8'($urandom), c, cc, "R2");
         if (i % 150 == 149) do_reset();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule